// File: doc/BRIEF.md
# Melody and Buzzer Tone Generator

This block drives one square-wave audio pin from a timebase in which every clock cycle is one tick of a 32.768 kHz reference. It has two uses. In melody mode software loads a note as a pitch code and a length code. The block plays the pitch for the length, scaled by a tempo setting. When the note runs out it emits a one-cycle note-end pulse, so that the next note can be written. In buzzer mode the block instead produces a fixed alarm-style pattern, with a selectable pitch and a 16-step duty.

All configuration enters through a byte-wide write port with four addresses. The output level can be inverted, and the idle level follows that inversion. Disabling the block, or rewriting its control byte, stops all activity at once and clears every counter.

Top module: `tone_gen`

Register layout used by the requirements:
- Address 0 is the control byte: bit 0 enable, bit 1 buzzer mode, bit 2 invert, bits 4:3 pattern, bits 7:5 buzzer frequency code.
- Address 1 holds the pitch code in bits 4:0.
- Address 2 takes the length code in bits 5:0. Writing this address starts a note.
- Address 3 holds the tempo code in bits 3:0 and the duty code in bits 7:4.

## Requirements
- R1: After reset, toneOut is 0 and noteDone is 0. The block is disabled, not inverted and in melody mode.
- R2: The write port is decoded as described in the register layout above. A write takes effect at the clock edge on which wrEn is high.
- R3: A note with pitch code k, where 1 ≤ k ≤ 29, toggles with a half period of (33 − k) ticks. The note starts with the active level in the first cycle after the starting write.
- R4: Pitch codes 0, 30 and 31 are rests. A rest holds the output at its idle level for the full note duration and still ends with a note-end pulse.
- R5: A note lasts L × (16 − t) × 4 ticks, where L is the length code and t is the tempo code. A tempo code of 0 behaves like code 1.
- R6: A length-code write of 0 is ignored. No note starts and no note-end pulse follows.
- R7: noteDone is high for exactly one cycle, in the cycle right after the last cycle of a note. From that cycle on the output is idle.
- R8: In buzzer mode with frequency code f and duty code d, the tone period is 16 × (f + 1) ticks. The tone is active for the first (d + 1) × (f + 1) ticks of each period, counted from the control write.
- R9: The pattern field gates the buzzer tone with a gate of 64 ticks. Pattern 0 is on 64 ticks and off 64 ticks. Pattern 1 is on 64 ticks and off 192 ticks. Pattern 2 is on for the first 64 ticks only. Pattern 3 is always on.
- R10: In pattern 2, noteDone pulses once, in the cycle in which the gate first closes (64 cycles after the control write).
- R11: The invert bit XORs the tone output. The idle level is therefore 1 when the bit is set.
- R12: With the enable bit clear, the output is idle and no note-end pulse appears. Length writes made while disabled or in buzzer mode start no note.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each cycle is one 32.768 kHz tick |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| toneOut | output | 1 | Tone output after polarity selection |
| noteDone | output | 1 | One-cycle note-end or single-shot-end pulse |

## Verification
Every pitch code, including the three rest codes, is played once at a short fixed length. This shows that the half period and the starting level follow the code, and that rests stay silent yet still end with a pulse.

A tempo sweep at a fixed pitch, together with one maximum-length note, pins down the duration arithmetic, including the alias of tempo code 0. A full sweep over the buzzer frequency and duty codes in the continuous pattern separates the period from the active width. Each of the four patterns is then run long enough to see its gate repeat or stop.

Further runs check the cases where a write must be ignored. These are a zero length, a mid-note disable, and note writes made while disabled or in buzzer mode. Each run compares the output and the pulse cycle by cycle against the arithmetic.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int SCALE_W = 5;
  localparam int LEN_W   = 6;
  localparam int TEMPO_W = 4;
  localparam int DUTY_W  = 4;
  localparam int FREQ_W  = 3;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_PITCH = 2'd1,
    ADDR_LEN   = 2'd2,
    ADDR_TIME  = 2'd3
  } regAddr_e;

  typedef enum logic [1:0] {
    PAT_INT1 = 2'd0,
    PAT_INT2 = 2'd1,
    PAT_SHOT = 2'd2,
    PAT_CONT = 2'd3
  } buzzPat_e;

  typedef struct packed {
    logic               clearAll;
    logic               startNote;
    logic               buzzRun;
    logic               invert;
    logic [SCALE_W-1:0] scale;
    logic [LEN_W-1:0]   lenCode;
    logic [TEMPO_W-1:0] tempo;
    buzzPat_e           pattern;
    logic [FREQ_W-1:0]  freq;
    logic [DUTY_W-1:0]  duty;
  } toneCmd_t;
endpackage

// File: rtl/tone_ctrl.sv
module tone_ctrl
  import tone_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output toneCmd_t   cmd
);
  logic               enableR, buzzR, invR;
  buzzPat_e           patR;
  logic [FREQ_W-1:0]  freqR;
  logic [SCALE_W-1:0] scaleR;
  logic [TEMPO_W-1:0] tempoR;
  logic [DUTY_W-1:0]  dutyR;

  logic selCtrl, selPitch, selLen, selTime;

  assign selCtrl  = wrEn && (wrAddr == ADDR_CTRL);
  assign selPitch = wrEn && (wrAddr == ADDR_PITCH);
  assign selLen   = wrEn && (wrAddr == ADDR_LEN);
  assign selTime  = wrEn && (wrAddr == ADDR_TIME);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableR <= 1'b0;
      buzzR   <= 1'b0;
      invR    <= 1'b0;
      patR    <= PAT_INT1;
      freqR   <= '0;
      scaleR  <= '0;
      tempoR  <= '0;
      dutyR   <= '0;
    end else begin
      if (selCtrl) begin
        enableR <= wrData[0];
        buzzR   <= wrData[1];
        invR    <= wrData[2];
        patR    <= buzzPat_e'(wrData[4:3]);
        freqR   <= wrData[7:5];
      end
      if (selPitch) scaleR <= wrData[SCALE_W-1:0];
      if (selTime) begin
        tempoR <= wrData[TEMPO_W-1:0];
        dutyR  <= wrData[7:4];
      end
    end
  end

  // a control write restarts everything from a clean state
  always_comb begin
    cmd.clearAll  = selCtrl || !enableR;
    cmd.startNote = selLen && (wrData[LEN_W-1:0] != '0) && enableR && !buzzR;
    cmd.buzzRun   = enableR && buzzR;
    cmd.invert    = invR;
    cmd.scale     = scaleR;
    cmd.lenCode   = wrData[LEN_W-1:0];
    cmd.tempo     = tempoR;
    cmd.pattern   = patR;
    cmd.freq      = freqR;
    cmd.duty      = dutyR;
  end
endmodule

// File: rtl/tone_dpath.sv
module tone_dpath
  import tone_pkg::*;
#(
  parameter int NUM_SCALES = 29,
  parameter int BASE_TICKS = 4,
  parameter int GATE_TICKS = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  toneCmd_t cmd,
  output logic     toneOut,
  output logic     noteDone,
  output logic     melodyBusy
);
  localparam int SCALE_TOP = NUM_SCALES + 4;
  localparam int MAX_TEMPO = (1 << TEMPO_W) - 1;
  localparam int MAX_DUR   = ((1 << LEN_W) - 1) * MAX_TEMPO * BASE_TICKS;
  localparam int DUR_W     = $clog2(MAX_DUR + 1);
  localparam int PH_W      = $clog2(2 * (SCALE_TOP - 1));
  localparam int BZ_W      = $clog2(16 * (1 << FREQ_W)) + 1;
  localparam int GT_W      = $clog2(4 * GATE_TICKS + 1);

  // ---------------- melody section ----------------
  logic             playing, restR, noteDoneM;
  logic [DUR_W-1:0] durCnt, totalR, newTotal;
  logic [PH_W-1:0]  phCnt, halfR, newHalf;
  logic [TEMPO_W-1:0] effTempo;
  logic [TEMPO_W:0]   unitMul;
  logic             newRest, phWrap, melWave;

  always_comb begin
    effTempo = (cmd.tempo == '0) ? TEMPO_W'(1) : cmd.tempo;
    unitMul  = (TEMPO_W+1)'(MAX_TEMPO + 1) - {1'b0, effTempo};
    newTotal = DUR_W'(cmd.lenCode) * DUR_W'(unitMul) * DUR_W'(BASE_TICKS);
    newRest  = (cmd.scale == '0) || (int'(cmd.scale) > NUM_SCALES);
    newHalf  = newRest ? PH_W'(SCALE_TOP - 1) : PH_W'(SCALE_TOP - int'(cmd.scale));
    phWrap   = ({1'b0, phCnt} == ({halfR, 1'b0} - 1'b1));
    melWave  = playing && !restR && (phCnt < halfR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      playing   <= 1'b0;
      restR     <= 1'b0;
      noteDoneM <= 1'b0;
      durCnt    <= '0;
      totalR    <= '0;
      phCnt     <= '0;
      halfR     <= '0;
    end else begin
      noteDoneM <= 1'b0;
      if (cmd.clearAll) begin
        playing <= 1'b0;
        durCnt  <= '0;
        phCnt   <= '0;
      end else if (cmd.startNote) begin
        playing <= 1'b1;
        durCnt  <= '0;
        phCnt   <= '0;
        totalR  <= newTotal;
        halfR   <= newHalf;
        restR   <= newRest;
      end else if (playing) begin
        if (durCnt == totalR - 1'b1) begin
          playing   <= 1'b0;
          durCnt    <= '0;
          phCnt     <= '0;
          noteDoneM <= 1'b1;
        end else begin
          durCnt <= durCnt + 1'b1;
          phCnt  <= phWrap ? '0 : phCnt + 1'b1;
        end
      end
    end
  end

  // ---------------- buzzer section ----------------
  logic [BZ_W-1:0] bph, bPerM1, bHigh;
  logic [GT_W-1:0] gCnt;
  logic [FREQ_W:0] freqP1;
  logic [DUTY_W:0] dutyP1;
  logic            gateOn, shotDone, buzzWave;

  always_comb begin
    freqP1 = {1'b0, cmd.freq} + 1'b1;
    dutyP1 = {1'b0, cmd.duty} + 1'b1;
    bPerM1 = BZ_W'({freqP1, 4'b0000}) - 1'b1;
    bHigh  = BZ_W'(dutyP1) * BZ_W'(freqP1);
    gateOn = (cmd.pattern == PAT_CONT) || (gCnt < GT_W'(GATE_TICKS));
    buzzWave = cmd.buzzRun && gateOn && (bph < bHigh);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bph      <= '0;
      gCnt     <= '0;
      shotDone <= 1'b0;
    end else begin
      shotDone <= 1'b0;
      if (cmd.clearAll || !cmd.buzzRun) begin
        bph  <= '0;
        gCnt <= '0;
      end else begin
        bph <= (bph >= bPerM1) ? '0 : bph + 1'b1;
        unique case (cmd.pattern)
          PAT_INT1: gCnt <= (gCnt >= GT_W'(2 * GATE_TICKS - 1)) ? '0 : gCnt + 1'b1;
          PAT_INT2: gCnt <= (gCnt >= GT_W'(4 * GATE_TICKS - 1)) ? '0 : gCnt + 1'b1;
          PAT_SHOT: begin
            if (gCnt < GT_W'(GATE_TICKS)) gCnt <= gCnt + 1'b1;
            shotDone <= (gCnt == GT_W'(GATE_TICKS - 1));
          end
          default:  gCnt <= '0;
        endcase
      end
    end
  end

  assign toneOut    = (cmd.buzzRun ? buzzWave : melWave) ^ cmd.invert;
  assign noteDone   = noteDoneM || shotDone;
  assign melodyBusy = playing;
endmodule

// File: rtl/tone_gen.sv
module tone_gen
  import tone_pkg::*;
#(
  parameter int NUM_SCALES = 29,
  parameter int BASE_TICKS = 4,
  parameter int GATE_TICKS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       toneOut,
  output logic       noteDone
);
  toneCmd_t cmd;
  logic     melodyBusy;

  tone_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cmd    (cmd)
  );

  tone_dpath #(
    .NUM_SCALES (NUM_SCALES),
    .BASE_TICKS (BASE_TICKS),
    .GATE_TICKS (GATE_TICKS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .toneOut    (toneOut),
    .noteDone   (noteDone),
    .melodyBusy (melodyBusy)
  );
endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk (
  input logic clk,
  input logic rstN,
  input logic ctrlOff,
  input logic newInv,
  input logic toneOut,
  input logic noteDone,
  input logic melodyBusy,
  input logic buzzRun
);
  // R7: the note-end pulse never lasts two cycles
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    noteDone |=> !noteDone);

  // R12: a control write that clears enable leaves the pin idle, no pulse
  assert_disable_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOff |=> (toneOut == $past(newInv)) && !noteDone);

  // R12: melody playback never coexists with buzzer operation
  assert_buzz_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    buzzRun |-> !melodyBusy);

  // R10: a pulse only follows a playing note or a running buzzer
  assert_done_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    noteDone |-> ($past(melodyBusy) || $past(buzzRun)));
endmodule

bind tone_gen tone_gen_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlOff    (wrEn && (wrAddr == 2'd0) && !wrData[0]),
  .newInv     (wrData[2]),
  .toneOut    (toneOut),
  .noteDone   (noteDone),
  .melodyBusy (melodyBusy),
  .buzzRun    (cmd.buzzRun)
);

// File: tb/tone_gen_test.sv
module tone_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       toneOut, noteDone;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tone_gen uut (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .toneOut  (toneOut),
    .noteDone (noteDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ends on the negedge just after the writing edge (observation cycle 0)
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // observe a note: value reported is {tone,done}
  task automatic runNote(input int scale, input int len, input int tempo, input bit inv,
                         input string req);
    int eff, total, half, bad, act, exp;
    bit rest, eT, eD;
    bad = 0; act = 0; exp = 0;
    wr(2'd1, 8'(scale));
    wr(2'd3, 8'(tempo));
    wr(2'd2, 8'(len));
    eff = (tempo == 0) ? 1 : tempo;
    total = len * (16 - eff) * 4;
    rest = (scale == 0) || (scale > 29);
    half = 33 - scale;
    for (int j = 0; j <= total + 2; j++) begin
      eT = 1'b0;
      if (j < total && !rest) eT = ((j % (2 * half)) < half);
      eT = eT ^ inv;
      eD = (j == total);
      if (toneOut !== eT || noteDone !== eD) begin
        if (bad == 0) begin act = {toneOut, noteDone}; exp = {eT, eD}; end
        bad++;
      end
      @(negedge clk);
    end
    check(bad == 0, req, act, exp);
  endtask

  task automatic runBuzz(input int pat, input int f, input int d, input bit inv,
                         input int cycles, input string req);
    int per, hi, bad, act, exp;
    bit gate, eT, eD;
    bad = 0; act = 0; exp = 0;
    per = 16 * (f + 1);
    hi = (d + 1) * (f + 1);
    wr(2'd3, 8'(d << 4));
    wr(2'd0, 8'((f << 5) | (pat << 3) | (inv << 2) | 3));
    for (int j = 0; j < cycles; j++) begin
      case (pat)
        0: gate = (j % 128) < 64;
        1: gate = (j % 256) < 64;
        2: gate = j < 64;
        default: gate = 1'b1;
      endcase
      eT = (gate && ((j % per) < hi)) ^ inv;
      eD = (pat == 2) && (j == 64);
      if (toneOut !== eT || noteDone !== eD) begin
        if (bad == 0) begin act = {toneOut, noteDone}; exp = {eT, eD}; end
        bad++;
      end
      @(negedge clk);
    end
    check(bad == 0, req, act, exp);
  endtask

  // expect a constant level and no pulse for a number of cycles
  task automatic holdIdle(input bit lvl, input int cycles, input string req);
    int bad, act;
    bad = 0; act = 0;
    for (int j = 0; j < cycles; j++) begin
      if (toneOut !== lvl || noteDone !== 1'b0) begin
        if (bad == 0) act = {toneOut, noteDone};
        bad++;
      end
      @(negedge clk);
    end
    check(bad == 0, req, act, {lvl, 1'b0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(toneOut == 1'b0 && noteDone == 1'b0, "R1 reset outputs", {toneOut, noteDone}, 0);
    rstN = 1'b1;
    holdIdle(1'b0, 10, "R1 idle after reset");

    // R2 R3 R4 R7: every pitch code, melody mode, no inversion
    wr(2'd0, 8'h01);
    for (int s = 0; s < 32; s++) runNote(s, 8, 15, 1'b0, "R3 R4 R7 pitch sweep");

    // R5 R11: tempo sweep with inverted output (tempo 0 aliases 1)
    wr(2'd0, 8'h05);
    for (int t = 0; t < 16; t++) runNote(20, 3, t, 1'b1, "R5 R11 tempo sweep");
    // R5: longest note
    runNote(29, 63, 1, 1'b1, "R5 max length");

    // R6: zero length ignored
    wr(2'd2, 8'h00);
    holdIdle(1'b1, 60, "R6 zero length");

    // R12: disable in the middle of a note
    wr(2'd0, 8'h01);
    wr(2'd1, 8'd10);
    wr(2'd3, 8'd1);
    wr(2'd2, 8'd20);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h04);
    holdIdle(1'b1, 400, "R12 disable mid note");
    // R12: note write while disabled
    wr(2'd2, 8'd2);
    holdIdle(1'b1, 200, "R12 write while disabled");

    // R8: full frequency x duty sweep, continuous pattern
    for (int f = 0; f < 8; f++)
      for (int d = 0; d < 16; d++)
        runBuzz(3, f, d, 1'b0, 16 * (f + 1), "R8 buzzer period/duty");

    // R9 R10 R11: each gating pattern
    runBuzz(0, 0, 7, 1'b0, 300, "R9 intermittent 1");
    runBuzz(1, 1, 3, 1'b1, 600, "R9 R11 intermittent 2");
    runBuzz(2, 0, 7, 1'b0, 300, "R9 R10 single shot");
    runBuzz(3, 2, 5, 1'b1, 300, "R9 R11 continuous");

    // R12: note write ignored in buzzer mode (always-high tone, no pulse)
    wr(2'd3, 8'hF1);
    wr(2'd0, 8'h1B);
    wr(2'd2, 8'd1);
    holdIdle(1'b1, 300, "R12 note write in buzzer mode");

    // R7: melody works again after leaving buzzer mode
    wr(2'd0, 8'h01);
    runNote(1, 2, 15, 1'b0, "R3 R7 after buzzer");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule